// File: doc/BRIEF.md
# Warp Memory Request Coalescer

The coalescer takes a whole warp of per-thread memory accesses at once: an active mask, a byte address per thread, an access size per thread and, for stores, eight bytes of data per thread. It turns them into as few aligned block requests as it can. Each block request names one aligned memory block and gives a byte-enable mask for the bytes touched. It also gives an owner mask, so that a later stage knows which threads to hand the response to. For stores it also carries the merged write data.

Requests leave in a fixed order. The lowest-numbered thread that is still uncovered leads each request. Every aligned thread that is still pending and that falls in the leader's block joins that request. A misaligned access never merges with anything and leaves on its own. A new warp is accepted only after the previous one has been fully issued.

Top module: `warp_coalescer`

## Requirements
- R1: A warp is taken on a clock edge where in_valid and in_ready are both high. in_ready is high exactly when no block request of the current warp remains. A warp whose active mask is all zero produces no request.
- R2: When the leading thread is aligned, the owner mask holds every still-pending aligned thread whose block index equals the leader's. The block index is address divided by BLOCK_BYTES. No other thread joins.
- R3: The leader of each request is the lowest-numbered pending thread. out_blk_addr is the leader's address with its low log2(BLOCK_BYTES) bits cleared. One request retires per cycle when out_valid and out_ready are high. While out_ready is low, the request holds steady.
- R4: The size code is 0, 1, 2 or 3, meaning 1, 2, 4 or 8 bytes. An access is aligned when its address is a multiple of its size.
- R5: A misaligned leader is issued alone, with an owner mask of that single thread. Its byte mask covers offset up to offset+size-1, clipped at the end of the block.
- R6: Bit i of out_bmask stands for byte i of the block. It is the union of the bytes touched by the owner threads.
- R7: For a store, block byte i is out_wdata[8i+7:8i]. Byte k of a thread's data lands at block byte offset+k. When owners overlap on a byte, the higher-numbered thread's byte wins.
- R8: out_store repeats the warp's store flag. For a load warp, out_wdata is all zero.
- R9: After reset, out_valid is low and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Warp offered |
| in_ready | output | 1 | Coalescer idle, warp can be taken |
| in_store | input | 1 | 1 = store warp, 0 = load warp |
| in_mask | input | N_THREADS | Active thread mask |
| in_addr | input | N_THREADS*ADDR_W | Byte address of thread t at [t*ADDR_W +: ADDR_W] |
| in_size | input | N_THREADS*2 | Size code of thread t at [2t +: 2] |
| in_wdata | input | N_THREADS*64 | Store data of thread t at [64t +: 64], byte 0 lowest |
| out_valid | output | 1 | Block request present |
| out_ready | input | 1 | Downstream takes the request |
| out_store | output | 1 | Request is a store |
| out_blk_addr | output | ADDR_W | Aligned block address |
| out_bmask | output | BLOCK_BYTES | Byte enables within the block |
| out_owner | output | N_THREADS | Threads served by this request |
| out_wdata | output | BLOCK_BYTES*8 | Merged store data |

## Verification
The bench builds the block with 32 threads, 64-byte blocks and 32-bit addresses. With these values a full warp of 2-byte accesses exactly fills one block. A stride of one block per thread forces the worst case of 32 separate requests. An 8-byte access placed two bytes before a block end reaches the clipping rule. Random warps spread their addresses over a few neighbouring blocks, so mixed merges, overlapping stores and misaligned leaders all occur. A random stall on out_ready exercises the hold rule.

// File: rtl/coal_pkg.sv
package coal_pkg;
  typedef logic [1:0] size_code_t;
  localparam int LANE_DATA_W = 64;

  function automatic int unsigned size_bytes(size_code_t c);
    return 32'd1 << c;
  endfunction

  function automatic logic is_aligned(logic [2:0] low, size_code_t c);
    case (c)
      2'd0:    return 1'b1;
      2'd1:    return low[0] == 1'b0;
      2'd2:    return low[1:0] == 2'b00;
      default: return low == 3'b000;
    endcase
  endfunction
endpackage

// File: rtl/coal_lane.sv
module coal_lane
  import coal_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int BLOCK_BYTES = 64,
  localparam int OFF_W      = $clog2(BLOCK_BYTES),
  localparam int BLK_W      = ADDR_W - OFF_W
) (
  input  logic [ADDR_W-1:0]        addr,
  input  size_code_t               size,
  input  logic [LANE_DATA_W-1:0]   wdata,
  input  logic                     store,
  output logic [BLK_W-1:0]         blk,
  output logic                     aligned,
  output logic [BLOCK_BYTES-1:0]   bmask,
  output logic [BLOCK_BYTES*8-1:0] bdata
);
  localparam int BW = BLOCK_BYTES * 8;

  function automatic logic [BLOCK_BYTES-1:0] span(int lo, int n);
    logic [BLOCK_BYTES-1:0] m;
    for (int i = 0; i < BLOCK_BYTES; i++) m[i] = (i >= lo) && (i < lo + n);
    return m;
  endfunction

  logic [OFF_W-1:0] off;
  logic [BW-1:0]    ext;

  assign off     = addr[OFF_W-1:0];
  assign blk     = addr[ADDR_W-1:OFF_W];
  assign aligned = is_aligned(addr[2:0], size);
  assign bmask   = span(int'(off), int'(size_bytes(size)));
  assign ext     = {{(BW-LANE_DATA_W){1'b0}}, wdata & {LANE_DATA_W{store}}};
  assign bdata   = ext << {off, 3'b000};
endmodule

// File: rtl/coal_pick.sv
module coal_pick #(
  parameter int N_THREADS = 32
) (
  input  logic [N_THREADS-1:0] pend,
  output logic [N_THREADS-1:0] lead_oh
);
  always_comb begin
    lead_oh = '0;
    for (int t = N_THREADS - 1; t >= 0; t--)
      if (pend[t]) lead_oh = N_THREADS'(1) << t;
  end
endmodule

// File: rtl/coal_merge.sv
module coal_merge #(
  parameter int N_THREADS   = 32,
  parameter int BLOCK_BYTES = 64
) (
  input  logic [N_THREADS-1:0]               owner,
  input  logic [N_THREADS*BLOCK_BYTES-1:0]   lane_bmask,
  input  logic [N_THREADS*BLOCK_BYTES*8-1:0] lane_bdata,
  output logic [BLOCK_BYTES-1:0]             bmask,
  output logic [BLOCK_BYTES*8-1:0]           wdata
);
  always_comb begin
    bmask = '0;
    wdata = '0;
    for (int b = 0; b < BLOCK_BYTES; b++)
      for (int t = 0; t < N_THREADS; t++)
        if (owner[t] && lane_bmask[t*BLOCK_BYTES+b]) begin
          bmask[b]        = 1'b1;
          wdata[b*8 +: 8] = lane_bdata[(t*BLOCK_BYTES+b)*8 +: 8];
        end
  end
endmodule

// File: rtl/warp_coalescer.sv
module warp_coalescer
  import coal_pkg::*;
#(
  parameter int N_THREADS   = 32,
  parameter int ADDR_W      = 32,
  parameter int BLOCK_BYTES = 64
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           in_valid,
  output logic                           in_ready,
  input  logic                           in_store,
  input  logic [N_THREADS-1:0]           in_mask,
  input  logic [N_THREADS*ADDR_W-1:0]    in_addr,
  input  logic [N_THREADS*2-1:0]         in_size,
  input  logic [N_THREADS*64-1:0]        in_wdata,
  output logic                           out_valid,
  input  logic                           out_ready,
  output logic                           out_store,
  output logic [ADDR_W-1:0]              out_blk_addr,
  output logic [BLOCK_BYTES-1:0]         out_bmask,
  output logic [N_THREADS-1:0]           out_owner,
  output logic [BLOCK_BYTES*8-1:0]       out_wdata
);
  localparam int OFF_W = $clog2(BLOCK_BYTES);
  localparam int BLK_W = ADDR_W - OFF_W;
  localparam int BW    = BLOCK_BYTES * 8;

  // warp state
  logic [N_THREADS-1:0]           pend;
  logic [N_THREADS*ADDR_W-1:0]    r_addr;
  logic [N_THREADS*2-1:0]         r_size;
  logic [N_THREADS*64-1:0]        r_wdata;
  logic                           r_store;

  // named internal events
  logic                           take_warp;
  logic                           retire;
  logic                           lead_mis;
  logic [N_THREADS-1:0]           lead_oh;
  logic [N_THREADS-1:0]           lane_aligned;
  logic [N_THREADS-1:0]           same_blk;
  logic [BLK_W-1:0]               lane_blk [N_THREADS];
  logic [BLK_W-1:0]               lead_blk;
  logic [N_THREADS*BLOCK_BYTES-1:0] lane_bmask;
  logic [N_THREADS*BW-1:0]        lane_bdata;
  logic [N_THREADS-1:0]           owner;

  assign out_valid = |pend;
  assign in_ready  = ~out_valid;
  assign take_warp = in_valid && in_ready;
  assign retire    = out_valid && out_ready;

  for (genvar t = 0; t < N_THREADS; t++) begin : g_lane
    coal_lane #(
      .ADDR_W      (ADDR_W),
      .BLOCK_BYTES (BLOCK_BYTES)
    ) u_lane (
      .addr    (r_addr[t*ADDR_W +: ADDR_W]),
      .size    (r_size[t*2 +: 2]),
      .wdata   (r_wdata[t*64 +: 64]),
      .store   (r_store),
      .blk     (lane_blk[t]),
      .aligned (lane_aligned[t]),
      .bmask   (lane_bmask[t*BLOCK_BYTES +: BLOCK_BYTES]),
      .bdata   (lane_bdata[t*BW +: BW])
    );
  end

  coal_pick #(.N_THREADS(N_THREADS)) u_pick (
    .pend    (pend),
    .lead_oh (lead_oh)
  );

  always_comb begin
    lead_blk = '0;
    for (int t = 0; t < N_THREADS; t++)
      if (lead_oh[t]) lead_blk = lead_blk | lane_blk[t];
  end

  always_comb begin
    for (int t = 0; t < N_THREADS; t++) same_blk[t] = (lane_blk[t] == lead_blk);
  end

  assign lead_mis = |(lead_oh & ~lane_aligned);
  assign owner    = lead_mis ? lead_oh : (pend & lane_aligned & same_blk);

  coal_merge #(
    .N_THREADS   (N_THREADS),
    .BLOCK_BYTES (BLOCK_BYTES)
  ) u_merge (
    .owner      (owner),
    .lane_bmask (lane_bmask),
    .lane_bdata (lane_bdata),
    .bmask      (out_bmask),
    .wdata      (out_wdata)
  );

  assign out_owner    = owner;
  assign out_store    = r_store;
  assign out_blk_addr = {lead_blk, {OFF_W{1'b0}}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend    <= '0;
      r_addr  <= '0;
      r_size  <= '0;
      r_wdata <= '0;
      r_store <= 1'b0;
    end else if (take_warp) begin
      pend    <= in_mask;
      r_addr  <= in_addr;
      r_size  <= in_size;
      r_wdata <= in_wdata;
      r_store <= in_store;
    end else if (retire) begin
      pend    <= pend & ~owner;
    end
  end
endmodule

// File: rtl/coal_checker.sv
module coal_checker #(
  parameter int N_THREADS   = 32,
  parameter int ADDR_W      = 32,
  parameter int BLOCK_BYTES = 64
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   in_valid,
  input logic                   in_ready,
  input logic [N_THREADS-1:0]   in_mask,
  input logic                   out_valid,
  input logic                   out_ready,
  input logic [N_THREADS-1:0]   out_owner,
  input logic [ADDR_W-1:0]      out_blk_addr,
  input logic [BLOCK_BYTES-1:0] out_bmask,
  input logic [N_THREADS-1:0]   pend,
  input logic                   lead_mis
);
  a_r1_warp_issues: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && (in_mask != '0) |=> out_valid);

  a_r1_empty_warp: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && (in_mask == '0) |=> in_ready);

  a_r2_owner_pending: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_owner != '0) && ((out_owner & ~pend) == '0));

  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_owner)
      && $stable(out_blk_addr) && $stable(out_bmask));

  a_r3_retire: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready |=> (pend & $past(out_owner)) == '0);

  a_r5_misaligned_alone: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && lead_mis |-> $countones(out_owner) == 1);

  a_r6_bytes_present: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_bmask != '0);
endmodule

bind warp_coalescer coal_checker #(
  .N_THREADS   (N_THREADS),
  .ADDR_W      (ADDR_W),
  .BLOCK_BYTES (BLOCK_BYTES)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .in_valid     (in_valid),
  .in_ready     (in_ready),
  .in_mask      (in_mask),
  .out_valid    (out_valid),
  .out_ready    (out_ready),
  .out_owner    (out_owner),
  .out_blk_addr (out_blk_addr),
  .out_bmask    (out_bmask),
  .pend         (pend),
  .lead_mis     (lead_mis)
);

// File: tb/warp_coalescer_tb.sv
module warp_coalescer_tb;
  localparam int N  = 32;
  localparam int AW = 32;
  localparam int BB = 64;
  localparam int BW = BB * 8;
  typedef logic [BW-1:0] wide_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic in_store = 1'b0;
  logic [N-1:0] in_mask = '0;
  logic [N*AW-1:0] in_addr = '0;
  logic [N*2-1:0] in_size = '0;
  logic [N*64-1:0] in_wdata = '0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic out_store;
  logic [AW-1:0] out_blk_addr;
  logic [BB-1:0] out_bmask;
  logic [N-1:0] out_owner;
  logic [BW-1:0] out_wdata;

  always #4 clk = ~clk;  // 125 MHz

  warp_coalescer #(.N_THREADS(N), .ADDR_W(AW), .BLOCK_BYTES(BB)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_store(in_store), .in_mask(in_mask), .in_addr(in_addr), .in_size(in_size),
    .in_wdata(in_wdata), .out_valid(out_valid), .out_ready(out_ready),
    .out_store(out_store), .out_blk_addr(out_blk_addr), .out_bmask(out_bmask),
    .out_owner(out_owner), .out_wdata(out_wdata)
  );

  int checks = 0;
  int errors = 0;

  // stimulus
  int unsigned t_addr [N];
  logic [1:0]  t_sz   [N];
  logic [63:0] t_wd   [N];
  logic [N-1:0] t_mask;
  logic t_store;

  // expected requests
  int n_exp;
  logic [N-1:0]  e_own [N];
  logic [AW-1:0] e_blk [N];
  logic [BB-1:0] e_bm  [N];
  wide_t         e_wd  [N];
  logic          e_mis [N];

  task automatic chk(input bit ok, input string req, input string what,
                     input wide_t act, input wide_t exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic clr();
    t_mask = '0;
    t_store = 1'b0;
    for (int t = 0; t < N; t++) begin
      t_addr[t] = 0; t_sz[t] = 2'd0; t_wd[t] = '0;
    end
  endtask

  task automatic build_expected();
    logic [N-1:0] left;
    left = t_mask;
    n_exp = 0;
    while (left != '0) begin
      int lead;
      int unsigned lb;
      bit mis;
      logic [N-1:0] own;
      logic [BB-1:0] bm;
      wide_t wd;
      lead = 0;
      while (!left[lead]) lead++;
      mis = (t_addr[lead] % (32'd1 << t_sz[lead])) != 0;
      lb = t_addr[lead] / BB;
      own = '0;
      for (int t = 0; t < N; t++)
        if (left[t]) begin
          if (mis) own[t] = (t == lead);
          else own[t] = ((t_addr[t] % (32'd1 << t_sz[t])) == 0) && (t_addr[t] / BB == lb);
        end
      bm = '0;
      wd = '0;
      for (int t = 0; t < N; t++)
        if (own[t]) begin
          int off;
          off = int'(t_addr[t] % BB);
          for (int k = 0; k < (1 << t_sz[t]); k++)
            if (off + k < BB) begin
              bm[off+k] = 1'b1;
              if (t_store) wd[(off+k)*8 +: 8] = t_wd[t][k*8 +: 8];
            end
        end
      e_own[n_exp] = own;
      e_blk[n_exp] = lb * BB;
      e_bm[n_exp]  = bm;
      e_wd[n_exp]  = wd;
      e_mis[n_exp] = mis;
      n_exp++;
      left = left & ~own;
    end
  endtask

  // called at a negative edge
  task automatic run_warp();
    int idx;
    build_expected();
    in_mask  = t_mask;
    in_store = t_store;
    for (int t = 0; t < N; t++) begin
      in_addr[t*AW +: AW] = t_addr[t];
      in_size[t*2 +: 2]   = t_sz[t];
      in_wdata[t*64 +: 64] = t_wd[t];
    end
    chk(in_ready == 1'b1, "R1", "in_ready before warp", wide_t'(in_ready), wide_t'(1));
    in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    idx = 0;
    while (idx < n_exp) begin
      bit rdy;
      if (!out_valid) begin
        chk(1'b0, "R3", "request missing", wide_t'(out_valid), wide_t'(1));
        break;
      end
      chk(in_ready == 1'b0, "R1", "in_ready while busy", wide_t'(in_ready), wide_t'(0));
      chk(out_owner == e_own[idx], e_mis[idx] ? "R5" : "R2", "owner",
          wide_t'(out_owner), wide_t'(e_own[idx]));
      chk(out_blk_addr == e_blk[idx], "R3", "block address",
          wide_t'(out_blk_addr), wide_t'(e_blk[idx]));
      chk(out_bmask == e_bm[idx], e_mis[idx] ? "R5" : "R6", "byte mask",
          wide_t'(out_bmask), wide_t'(e_bm[idx]));
      chk(out_wdata == e_wd[idx], t_store ? "R7" : "R8", "write data",
          out_wdata, e_wd[idx]);
      chk(out_store == t_store, "R8", "store flag", wide_t'(out_store), wide_t'(t_store));
      rdy = ($urandom % 4) != 0;
      out_ready = rdy;
      @(posedge clk);
      if (rdy) idx++;
      @(negedge clk);
    end
    out_ready = 1'b1;
    chk(!out_valid && in_ready, "R1", "idle after warp",
        wide_t'({out_valid, in_ready}), wide_t'(2'b01));
  endtask

  task automatic rand_warp();
    int unsigned base;
    clr();
    base = ($urandom % 16) * BB;
    t_store = $urandom % 2;
    for (int t = 0; t < N; t++) begin
      t_mask[t] = ($urandom % 4) != 0;
      t_sz[t]   = 2'($urandom % 4);
      t_addr[t] = base + ($urandom % 256);
      if ($urandom % 2 == 1) t_addr[t] = t_addr[t] & ~((32'd1 << t_sz[t]) - 1);
      t_wd[t]   = {$urandom, $urandom};
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240607));
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk(!out_valid && in_ready, "R9", "reset state",
        wide_t'({out_valid, in_ready}), wide_t'(2'b01));

    // R2 R6: full warp of 2-byte stores fills one block
    clr(); t_store = 1'b1; t_mask = '1;
    for (int t = 0; t < N; t++) begin
      t_addr[t] = 32'h1000 + t * 2; t_sz[t] = 2'd1; t_wd[t] = 64'h1111 * (t + 1);
    end
    run_warp();

    // R3: one block per thread, descending addresses, issue in thread order
    clr(); t_mask = '1;
    for (int t = 0; t < N; t++) begin
      t_addr[t] = 32'h8000 + (N - 1 - t) * BB + 4; t_sz[t] = 2'd2;
    end
    run_warp();

    // R4 R5: misaligned leaders, one clipped at the block end
    clr(); t_store = 1'b1; t_mask = 32'h0000_00FF;
    t_addr[0] = 32'h2001; t_sz[0] = 2'd2; t_wd[0] = 64'hA1A2A3A4;
    t_addr[1] = 32'h2004; t_sz[1] = 2'd2; t_wd[1] = 64'hB1B2B3B4;
    t_addr[2] = 32'h2008; t_sz[2] = 2'd3; t_wd[2] = 64'hC1C2C3C4C5C6C7C8;
    t_addr[3] = 32'h203E; t_sz[3] = 2'd3; t_wd[3] = 64'hD1D2D3D4D5D6D7D8;
    t_addr[4] = 32'h2006; t_sz[4] = 2'd1; t_wd[4] = 64'hE1E2;
    t_addr[5] = 32'h2007; t_sz[5] = 2'd1; t_wd[5] = 64'hF1F2;
    t_addr[6] = 32'h2003; t_sz[6] = 2'd0; t_wd[6] = 64'h77;
    t_addr[7] = 32'h2010; t_sz[7] = 2'd3; t_wd[7] = 64'h0123456789ABCDEF;
    run_warp();

    // R7: overlapping stores, highest thread wins
    clr(); t_store = 1'b1; t_mask = 32'h0000_000F;
    for (int t = 0; t < 4; t++) begin
      t_addr[t] = 32'h3000; t_sz[t] = 2'd1; t_wd[t] = 64'h1010 * (t + 1);
    end
    t_sz[2] = 2'd2;
    run_warp();

    // R1: empty mask produces nothing
    clr(); t_store = 1'b1;
    for (int t = 0; t < N; t++) t_addr[t] = t * 8;
    run_warp();

    // R8: load warp with nonzero data inputs
    clr(); t_mask = 32'hF0F0_F0F0;
    for (int t = 0; t < N; t++) begin
      t_addr[t] = 32'h4000 + t * 8; t_sz[t] = 2'd3; t_wd[t] = 64'hFFFF_FFFF_FFFF_FFFF;
    end
    run_warp();

    // random warps covering R2 to R8
    for (int i = 0; i < 250; i++) begin
      rand_warp();
      run_warp();
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule